// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Mapping

This block produces the 12-bit address of the next microinstruction in a horizontally microcoded processor. In every cycle it picks one of four address sources: the micro-program counter, the immediate field of the current microword, the top of a four-entry return stack, or a start address looked up from the opcode held in its instruction register. A 3-bit next-address code from the microword and one condition bit index a 16-entry sequence table. Each table entry gives a source select, a stack enable (active low) and a push/pop direction.

The chosen address is ORed with an external mask, which lets interrupt logic steer the flow to vector addresses. The result drives the microprogram store. The micro-program counter always takes the driven address plus one. The instruction register captures the data bus only in a cycle where the microword's active-low load bit is low. In a real program this is the fetch step. While the active-low reset is low, the output address is held at zero and all state is cleared on the clock edge.

The sequence table entries, indexed by {code, condition}, are as follows:
- Code 0 is a conditional jump.
- Code 1 dispatches through the opcode map, or jumps when the condition is set.
- Code 2 is a conditional call.
- Code 3 returns when the condition is set and otherwise jumps.
- Code 4 calls when the condition is set and otherwise repeats the top of stack without popping.
- Code 5 always pops, then jumps when the condition is set and otherwise continues.
- Code 6 jumps when the condition is clear and otherwise continues.
- Code 7 always continues.

Top module: `useq_core`

## Requirements
- R1: While `rst_n` is low, `uaddr` is 0 regardless of every other input. A clock edge with `rst_n` low sets the micro-PC to 1, empties the stack to all zeros and clears the instruction register to 0x00.
- R2: Continue (code 7, code 0 with cond 0, code 2 with cond 0, code 6 with cond 1) drives the micro-PC, which equals the previous cycle's `uaddr` plus one, wrapping modulo 4096.
- R3: Code 0 with cond 1 drives `imm`. Code 0 with cond 0 continues.
- R4: Code 1 with cond 0 drives the mapped start address of the registered opcode. That address is 0x004 for opcode 0x00 and 0x100 | opcode for any other opcode, so bits 11..9 are always zero. Code 1 with cond 1 drives `imm`.
- R5: The instruction register takes `dbus` at a clock edge only when `ir_load_n` is low. Otherwise the bus value has no effect on later map dispatches.
- R6: Code 2 with cond 1 and code 4 with cond 1 drive `imm` and push the current micro-PC onto the stack.
- R7: Code 3 with cond 1 drives the top of stack and pops it. Code 3 with cond 0 drives `imm`.
- R8: Code 4 with cond 0 drives the top of stack and leaves the stack unchanged.
- R9: Code 5 pops the stack. With cond 0 it continues, and with cond 1 it drives `imm`.
- R10: Code 6 with cond 0 drives `imm` and with cond 1 continues. Code 7 continues for either cond value.
- R11: The stack holds 4 entries and its pointer wraps. A fifth push overwrites the oldest entry, and pops cycle through the entries modulo 4.
- R12: Outside reset, `uaddr` is the selected source ORed with `or_mask`. The micro-PC follows the masked value plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low zero/reset |
| nxt_code | input | 3 | Next-address code from the microword |
| cond | input | 1 | Condition bit for the sequence table |
| imm | input | 12 | Immediate address field from the microword |
| ir_load_n | input | 1 | Active-low instruction register load |
| dbus | input | 8 | Data bus feeding the instruction register |
| or_mask | input | 12 | Mask ORed onto the output address |
| uaddr | output | 12 | Microprogram address |

## Verification
A wrong micro-PC shows up in the same cycle as a continue step whose address is not the previous one plus one. A stack pointer or stack entry that is off stays hidden until the next return or repeat step, which then drives a stale address; a call-then-return check and the wrap test expose it. An instruction register that was loaded when it should not have been, or not loaded when it should, shows up only at the next map dispatch, so every dispatch is preceded by a cycle with a known load decision.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        SRC_UPC = 2'b00,
        SRC_IMM = 2'b01,
        SRC_TOS = 2'b10,
        SRC_MAP = 2'b11
    } src_e;

    typedef struct packed {
        logic spare;
        logic file_n;
        logic push;
        src_e src;
    } seq_ctl_t;

    typedef enum logic [1:0] {
        STK_HOLD = 2'b00,
        STK_PUSH = 2'b01,
        STK_POP  = 2'b10
    } stk_op_e;

endpackage

// File: rtl/useq_seq_table.sv
module useq_seq_table
    import useq_pkg::*;
(
    input  logic [2:0] code,
    input  logic       cond,
    output seq_ctl_t   ctl
);

    logic [4:0] word;

    always_comb begin
        unique case ({code, cond})
            4'd0:  word = 5'b01000;
            4'd1:  word = 5'b01001;
            4'd2:  word = 5'b01011;
            4'd3:  word = 5'b01001;
            4'd4:  word = 5'b01000;
            4'd5:  word = 5'b00101;
            4'd6:  word = 5'b01001;
            4'd7:  word = 5'b00010;
            4'd8:  word = 5'b11010;
            4'd9:  word = 5'b00101;
            4'd10: word = 5'b00000;
            4'd11: word = 5'b00001;
            4'd12: word = 5'b01001;
            4'd13: word = 5'b01000;
            4'd14: word = 5'b01000;
            4'd15: word = 5'b01000;
        endcase
    end

    assign ctl = seq_ctl_t'(word);

endmodule

// File: rtl/useq_map.sv
module useq_map #(
    parameter int AW       = 12,
    parameter int OPW      = 8,
    parameter int MAP_BITS = 9,
    parameter logic [AW-1:0] FETCH_ADDR = 12'h004
) (
    input  logic [OPW-1:0] op,
    output logic [AW-1:0]  start
);

    always_comb begin
        start              = '0;
        start[OPW-1:0]     = op;
        start[MAP_BITS-1]  = 1'b1;
        if (op == '0) begin
            start = FETCH_ADDR;
        end
    end

endmodule

// File: rtl/useq_stack.sv
module useq_stack
    import useq_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_op_e       op,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] tos
);

    localparam int SPW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0]  mem [DEPTH];
    logic [SPW-1:0] sp_q;
    logic [SPW-1:0] sp_up;
    logic [SPW-1:0] sp_dn;

    assign sp_up = sp_q + 1'b1;
    assign sp_dn = sp_q - 1'b1;
    assign tos   = mem[sp_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            unique case (op)
                STK_PUSH: begin
                    mem[sp_up] <= din;
                    sp_q       <= sp_up;
                end
                STK_POP:  sp_q <= sp_dn;
                default:  sp_q <= sp_q;
            endcase
        end
    end

endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
#(
    parameter int AW       = 12,
    parameter int OPW      = 8,
    parameter int DEPTH    = 4,
    parameter int MAP_BITS = 9,
    parameter logic [AW-1:0] FETCH_ADDR = 12'h004
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     nxt_code,
    input  logic           cond,
    input  logic [AW-1:0]  imm,
    input  logic           ir_load_n,
    input  logic [OPW-1:0] dbus,
    input  logic [AW-1:0]  or_mask,
    output logic [AW-1:0]  uaddr
);

    localparam logic [AW-1:0] UPC_AFTER_RST = AW'(1);

    seq_ctl_t       ctl;
    stk_op_e        stk_op;
    logic [AW-1:0]  upc_q;
    logic [OPW-1:0] ir_q;
    logic [AW-1:0]  map_addr;
    logic [AW-1:0]  tos;
    logic [AW-1:0]  src_val;

    useq_seq_table u_table (
        .code (nxt_code),
        .cond (cond),
        .ctl  (ctl)
    );

    useq_map #(
        .AW         (AW),
        .OPW        (OPW),
        .MAP_BITS   (MAP_BITS),
        .FETCH_ADDR (FETCH_ADDR)
    ) u_map (
        .op    (ir_q),
        .start (map_addr)
    );

    useq_stack #(
        .AW    (AW),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (stk_op),
        .din   (upc_q),
        .tos   (tos)
    );

    always_comb begin
        unique case (ctl.src)
            SRC_UPC: src_val = upc_q;
            SRC_IMM: src_val = imm;
            SRC_TOS: src_val = tos;
            SRC_MAP: src_val = map_addr;
        endcase
    end

    always_comb begin
        if (!rst_n || ctl.file_n) begin
            stk_op = STK_HOLD;
        end else if (ctl.push) begin
            stk_op = STK_PUSH;
        end else begin
            stk_op = STK_POP;
        end
    end

    assign uaddr = rst_n ? (src_val | or_mask) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upc_q <= UPC_AFTER_RST;
            ir_q  <= '0;
        end else begin
            upc_q <= uaddr + AW'(1);
            if (!ir_load_n) begin
                ir_q <= dbus;
            end
        end
    end

endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    nxt_code,
    input logic          cond,
    input logic [AW-1:0] imm,
    input logic [AW-1:0] or_mask,
    input logic [AW-1:0] uaddr,
    input logic [AW-1:0] upc_q
);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |-> uaddr == '0);

    // R2
    cont_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_code == 3'd7 && or_mask == '0) |-> uaddr == AW'($past(uaddr) + 1'b1));

    // R3
    cond_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_code == 3'd0 && cond) |-> uaddr == (imm | or_mask));

    // R7
    call_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_code == 3'd2 && cond) |=>
        (!(nxt_code == 3'd3 && cond && or_mask == '0) || uaddr == $past(upc_q)));

    // R8
    tos_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_code == 3'd4 && !cond && or_mask == '0) |=>
        (!(nxt_code == 3'd4 && !cond && or_mask == '0) || uaddr == $past(uaddr)));

    // R12
    mask_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr & or_mask) == or_mask);

endmodule

bind useq_core useq_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .nxt_code (nxt_code),
    .cond     (cond),
    .imm      (imm),
    .or_mask  (or_mask),
    .uaddr    (uaddr),
    .upc_q    (upc_q)
);

// File: tb/useq_core_bench.sv
`timescale 1ns/100ps
module useq_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  nxt_code = 3'd7;
    logic        cond = 1'b0;
    logic [11:0] imm = '0;
    logic        ir_load_n = 1'b1;
    logic [7:0]  dbus = '0;
    logic [11:0] or_mask = '0;
    logic [11:0] uaddr;

    always #2.5 clk = ~clk;

    useq_core u_useq_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_code  (nxt_code),
        .cond      (cond),
        .imm       (imm),
        .ir_load_n (ir_load_n),
        .dbus      (dbus),
        .or_mask   (or_mask),
        .uaddr     (uaddr)
    );

    typedef struct {
        logic [11:0] addr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // reference model state
    logic [11:0] m_upc;
    logic [7:0]  m_ir;
    logic [11:0] m_stk [4];
    logic [1:0]  m_sp;

    function automatic logic [11:0] map_ref(input logic [7:0] op);
        return (op == 8'h00) ? 12'h004 : (12'h100 | {4'h0, op});
    endfunction

    task automatic step(input logic [2:0] c, input logic cd, input logic [11:0] im,
                        input logic [11:0] mk, input logic irn, input logic [7:0] db,
                        input logic rn, input string tag);
        logic [11:0] y;
        logic [11:0] base;
        bit push;
        bit pop;
        @(posedge clk);
        #1;
        nxt_code = c; cond = cd; imm = im; or_mask = mk;
        ir_load_n = irn; dbus = db; rst_n = rn;
        push = 0; pop = 0;
        if (!rn) begin
            y = '0;
        end else begin
            base = m_upc;
            case (c)
                3'd0: base = cd ? im : m_upc;
                3'd1: base = cd ? im : map_ref(m_ir);
                3'd2: begin base = cd ? im : m_upc; push = cd; end
                3'd3: begin base = cd ? m_stk[m_sp] : im; pop = cd; end
                3'd4: begin base = cd ? im : m_stk[m_sp]; push = cd; end
                3'd5: begin base = cd ? im : m_upc; pop = 1; end
                3'd6: base = cd ? m_upc : im;
                default: base = m_upc;
            endcase
            y = base | mk;
        end
        exp_q.push_back('{y, tag});
        if (!rn) begin
            m_upc = 12'h001; m_ir = 8'h00; m_sp = 2'd0;
            for (int i = 0; i < 4; i++) m_stk[i] = '0;
        end else begin
            if (push) begin
                m_sp = m_sp + 2'd1;
                m_stk[m_sp] = m_upc;
            end else if (pop) begin
                m_sp = m_sp - 2'd1;
            end
            m_upc = y + 12'd1;
            if (!irn) m_ir = db;
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_run++;
                if (uaddr !== e.addr) begin
                    n_fail++;
                    $display("FAIL %s: uaddr=%h expected=%h", e.tag, uaddr, e.addr);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset holds zero even with mask and jump code
        step(3'd0, 1'b1, 12'hABC, 12'hF0F, 1'b0, 8'h77, 1'b0, "R1");
        step(3'd0, 1'b1, 12'hABC, 12'hF0F, 1'b0, 8'h77, 1'b0, "R1");
        step(3'd1, 1'b0, 12'h123, 12'h800, 1'b1, 8'h00, 1'b0, "R1");
        // R2: continue from reset
        step(3'd7, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R2");
        step(3'd7, 1'b1, 12'h555, 12'h000, 1'b1, 8'h00, 1'b1, "R2");
        step(3'd7, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R2");
        // R3: conditional jump
        step(3'd0, 1'b0, 12'h0A0, 12'h000, 1'b1, 8'h00, 1'b1, "R3");
        step(3'd0, 1'b1, 12'h0A0, 12'h000, 1'b1, 8'h00, 1'b1, "R3");
        step(3'd7, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R2");
        // R4 / R5: load opcode, then dispatch
        step(3'd7, 1'b0, 12'h000, 12'h000, 1'b0, 8'h3C, 1'b1, "R5");
        step(3'd1, 1'b0, 12'h000, 12'h000, 1'b1, 8'h55, 1'b1, "R4");
        step(3'd7, 1'b0, 12'h000, 12'h000, 1'b1, 8'hAA, 1'b1, "R5");
        step(3'd1, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R5");
        step(3'd1, 1'b1, 12'h2F0, 12'h000, 1'b0, 8'h00, 1'b1, "R4");
        step(3'd1, 1'b0, 12'h000, 12'h000, 1'b0, 8'hFF, 1'b1, "R4");
        step(3'd1, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R4");
        // R6 / R7: call then return
        step(3'd2, 1'b0, 12'h200, 12'h000, 1'b1, 8'h00, 1'b1, "R6");
        step(3'd2, 1'b1, 12'h200, 12'h000, 1'b1, 8'h00, 1'b1, "R6");
        step(3'd7, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R2");
        step(3'd3, 1'b1, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R7");
        step(3'd3, 1'b0, 12'h345, 12'h000, 1'b1, 8'h00, 1'b1, "R7");
        // R8 / R9: call via code 4, repeat top, pop
        step(3'd4, 1'b1, 12'h300, 12'h000, 1'b1, 8'h00, 1'b1, "R6");
        step(3'd4, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R8");
        step(3'd4, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R8");
        step(3'd2, 1'b1, 12'h310, 12'h000, 1'b1, 8'h00, 1'b1, "R6");
        step(3'd5, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R9");
        step(3'd4, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R9");
        step(3'd5, 1'b1, 12'h0F0, 12'h000, 1'b1, 8'h00, 1'b1, "R9");
        step(3'd4, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R9");
        // R10
        step(3'd6, 1'b0, 12'h444, 12'h000, 1'b1, 8'h00, 1'b1, "R10");
        step(3'd6, 1'b1, 12'h999, 12'h000, 1'b1, 8'h00, 1'b1, "R10");
        step(3'd7, 1'b1, 12'h999, 12'h000, 1'b1, 8'h00, 1'b1, "R10");
        // R11: five pushes, six returns
        for (int k = 0; k < 5; k++)
            step(3'd2, 1'b1, 12'h400 + 12'(k * 16), 12'h000, 1'b1, 8'h00, 1'b1, "R11");
        for (int k = 0; k < 6; k++)
            step(3'd3, 1'b1, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R11");
        // R12: mask on several sources
        step(3'd7, 1'b0, 12'h000, 12'h800, 1'b1, 8'h00, 1'b1, "R12");
        step(3'd0, 1'b1, 12'h010, 12'h003, 1'b1, 8'h00, 1'b1, "R12");
        step(3'd7, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R12");
        step(3'd1, 1'b0, 12'h000, 12'h030, 1'b1, 8'h00, 1'b1, "R12");
        // wrap of micro-PC
        step(3'd0, 1'b1, 12'hFFF, 12'h000, 1'b1, 8'h00, 1'b1, "R2");
        step(3'd7, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R2");
        // R1 again mid-run
        step(3'd3, 1'b1, 12'h000, 12'hFFF, 1'b1, 8'h00, 1'b0, "R1");
        step(3'd4, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R1");
        step(3'd1, 1'b0, 12'h000, 12'h000, 1'b1, 8'h00, 1'b1, "R1");
        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule